// File: doc/BRIEF.md
# Four-Link Byte-Interleaved TDM Multiplexer

This block collects the receive data and signaling of four 2.048 Mbit/s links and places them on a single serial bus running at 8.192 MHz. Each link writes its timeslot bytes into the block through a simple write port. A write gives a timeslot number, an 8-bit data byte and a 4-bit signaling nibble. Writes fill one half of a per-link double buffer while the other half is shifted out, and the two halves swap at every frame boundary.

On the bus, each 125 µs frame holds 128 byte slots, and each slot is eight bus clocks long. The slots take the four links in rotation, so four consecutive slots carry the same timeslot number for links 1 to 4. The data line carries each data byte most significant bit first. The signaling line is aligned to the same slot. Its first four bit times are zero and its last four carry the nibble. A second pair of output lines repeats the primary pair bit for bit as a backup.

A frame-start pulse input, whose active level can be inverted, forces the bus to a frame boundary. With no pulse, the bus restarts a frame by itself every 1024 clocks.

Top module: `tdm_mux4`

## Requirements
- R1: While `rst_n` is low, `sd_a`, `sg_a`, `sd_b` and `sg_b` are 0 and both buffer halves are cleared. The first frame after reset starts on the first clock edge after release and carries all-zero bytes.
- R2: A frame is 1024 bus clocks, split into 128 byte slots of 8 clocks each. Slot k (0..127) carries link index (k mod 4) and timeslot (k div 4).
- R3: Within a slot, `sd_a` carries the data byte most significant bit first. Bit position p of the frame (0..1023) is driven on the clock edge that enters that position, so the frame's first bit appears right after the frame-boundary edge.
- R4: `sg_a` carries the byte {4'b0000, nibble} in the same slot as its data byte, most significant bit first. It is 0 for bit times 0 to 3 of every slot, and bit times 4 to 7 carry nibble bits 3 down to 0.
- R5: Each link's buffer is double. A byte written (`wr_en[l]` high at a clock edge, with timeslot `wr_ts[l*5+:5]`, data `wr_data[l*8+:8]` and nibble `wr_sig[l*4+:4]`) is sent in the frame that starts at the next frame boundary after the write.
- R6: The frame pulse is active when `fp_in` differs from `fp_inv`. With `fp_inv`=0 it is active high, and with `fp_inv`=1 it is active low. An inactive level has no effect.
- R7: An active frame pulse sampled at any clock edge makes that edge a frame boundary: the outputs show bit position 0 and the buffer halves swap. A pulse that arrives at the expected end of a frame leaves the timing the same as free-running.
- R8: With no active pulse, the frame boundary follows bit position 1023 automatically.
- R9: `sd_b` equals `sd_a` and `sg_b` equals `sg_a` in every cycle.
- R10: A write made at the same clock edge as a frame boundary goes into the newly freed buffer half. It is sent in the frame after the one that boundary starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock (8.192 MHz); all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_inv | input | 1 | Frame pulse polarity: 0 active high, 1 active low |
| fp_in | input | 1 | Frame-start pulse, sampled on the rising edge |
| wr_en | input | 4 | Per-link byte write strobe |
| wr_ts | input | 20 | Per-link timeslot number, 5 bits per link |
| wr_data | input | 32 | Per-link data byte, 8 bits per link |
| wr_sig | input | 16 | Per-link signaling nibble, 4 bits per link |
| sd_a | output | 1 | Multiplexed data line, primary |
| sg_a | output | 1 | Multiplexed signaling line, primary |
| sd_b | output | 1 | Multiplexed data line, backup |
| sg_b | output | 1 | Multiplexed signaling line, backup |

## Verification
Two functions can meet in one clock edge: a frame boundary, either forced by the pulse or reached by wrap-around, and a buffer write. Three cases arise. A write to the very slot about to be sent can land on the boundary edge, a resync pulse can arrive mid-frame while writes are in flight, and a pulse can coincide with the natural wrap. The bench provokes the first with directed writes on the boundary edge and the others with random writes and random resync pulses in both polarities. It judges every output bit against a bench model, which must send a boundary-edge write one frame later than a write made one clock earlier.

// File: rtl/tdm_mux4.sv
module tdm_mux4 #(
  parameter int NLINK = 4,
  parameter int NTS   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fp_inv,
  input  logic                         fp_in,
  input  logic [NLINK-1:0]             wr_en,
  input  logic [NLINK*$clog2(NTS)-1:0] wr_ts,
  input  logic [NLINK*8-1:0]           wr_data,
  input  logic [NLINK*4-1:0]           wr_sig,
  output logic                         sd_a,
  output logic                         sg_a,
  output logic                         sd_b,
  output logic                         sg_b
);
  localparam int SLOTS = NLINK * NTS;
  localparam int NPOS  = SLOTS * 8;
  localparam int PW    = $clog2(NPOS);
  localparam int LW    = $clog2(NLINK);
  localparam int TW    = $clog2(NTS);
  localparam int SW    = LW + TW;
  localparam int AW    = SW + 1;
  localparam int DEPTH = 2 * SLOTS;

  logic [11:0]   mem [DEPTH];
  logic [PW-1:0] cnt, nxt;
  logic          rb;

  wire           fp_act = fp_in ^ fp_inv;
  assign nxt = (fp_act || cnt == PW'(NPOS - 1)) ? '0 : cnt + 1'b1;
  wire           rb_n = (nxt == '0) ? ~rb : rb;

  wire [SW-1:0]  slot = nxt[PW-1:3];
  wire [2:0]     bsel = nxt[2:0];
  wire [AW-1:0]  raddr = {rb_n, slot[LW-1:0], slot[SW-1:LW]};
  wire [11:0]    rd = mem[raddr];
  wire [7:0]     dbyte = rd[11:4];
  wire [7:0]     sbyte = {4'b0000, rd[3:0]};
  wire           d_bit = dbyte[3'd7 - bsel];
  wire           s_bit = sbyte[3'd7 - bsel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= PW'(NPOS - 1);
      rb   <= 1'b0;
      sd_a <= 1'b0;
      sg_a <= 1'b0;
      sd_b <= 1'b0;
      sg_b <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt  <= nxt;
      rb   <= rb_n;
      sd_a <= d_bit;
      sg_a <= s_bit;
      sd_b <= d_bit;
      sg_b <= s_bit;
      for (int l = 0; l < NLINK; l++)
        if (wr_en[l])
          mem[{~rb_n, LW'(l), wr_ts[l*TW +: TW]}] <= {wr_data[l*8 +: 8], wr_sig[l*4 +: 4]};
    end
  end
endmodule

// File: rtl/tdm_mux4_chk.sv
module tdm_mux4_chk #(
  parameter int PW   = 10,
  parameter int NPOS = 1024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fp_in,
  input logic          fp_inv,
  input logic [PW-1:0] cnt,
  input logic          rb,
  input logic          sd_a,
  input logic          sg_a,
  input logic          sd_b,
  input logic          sg_b
);
  wire act = fp_in ^ fp_inv;

  AST_FP_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> cnt == '0); // R7
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && cnt == PW'(NPOS - 1)) |=> cnt == '0); // R8
  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && cnt != PW'(NPOS - 1)) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_BANK_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> rb != $past(rb)); // R5
  AST_BACKUP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_b == sd_a) && (sg_b == sg_a)); // R9
  AST_SIG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[2:0] < 3'd4) |-> !sg_a); // R4
endmodule

bind tdm_mux4 tdm_mux4_chk #(.PW(PW), .NPOS(NPOS)) u_chk (
  .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .fp_inv(fp_inv),
  .cnt(cnt), .rb(rb), .sd_a(sd_a), .sg_a(sg_a), .sd_b(sd_b), .sg_b(sg_b)
);

// File: tb/tdm_mux4_tb_top.sv
`timescale 1ns/1ps
module tdm_mux4_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fp_inv = 1'b0, fp_in = 1'b0;
  logic [3:0]  wr_en = '0;
  logic [19:0] wr_ts = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] wr_sig = '0;
  logic sd_a, sg_a, sd_b, sg_b;

  int checks = 0, failures = 0;
  bit done = 0;
  string tag;

  logic [11:0] mb [2][4][32];
  int mpos;
  bit mrb;

  always #4 clk = ~clk;

  tdm_mux4 dut_i (.clk(clk), .rst_n(rst_n), .fp_inv(fp_inv), .fp_in(fp_in),
    .wr_en(wr_en), .wr_ts(wr_ts), .wr_data(wr_data), .wr_sig(wr_sig),
    .sd_a(sd_a), .sg_a(sg_a), .sd_b(sd_b), .sg_b(sg_b));

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s pos=%0d actual=%b expected=%b", tag, what, mpos, act, exp);
    end
  endtask

  function automatic logic exp_bit(input bit sig);
    int slot = mpos >> 3;
    int b = mpos & 7;
    logic [11:0] e = mb[mrb][slot % 4][slot / 4];
    if (!sig) return e[11-b];
    return (b < 4) ? 1'b0 : e[7-b];
  endfunction

  task automatic cyc(input bit act, input bit force_w);
    int nxt;
    chk(sd_a, exp_bit(0), "R3 data");
    chk(sg_a, exp_bit(1), "R4 sig");
    chk(sd_b, sd_a, "R9 backup data");
    chk(sg_b, sg_a, "R9 backup sig");
    fp_in = fp_inv ^ act;
    for (int l = 0; l < 4; l++) begin
      wr_en[l] = force_w ? 1'b1 : ($urandom % 3 == 0);
      wr_ts[l*5 +: 5] = force_w ? (l == 3 ? 5'd31 : 5'd0) : 5'($urandom);
      wr_data[l*8 +: 8] = 8'($urandom);
      wr_sig[l*4 +: 4] = 4'($urandom);
    end
    nxt = act ? 0 : (mpos == 1023 ? 0 : mpos + 1);
    if (nxt == 0) mrb = ~mrb;
    mpos = nxt;
    for (int l = 0; l < 4; l++)
      if (wr_en[l]) mb[~mrb][l][wr_ts[l*5 +: 5]] = {wr_data[l*8 +: 8], wr_sig[l*4 +: 4]};
    @(negedge clk);
  endtask

  // mode 0: free run, 1: pulse at expected end, 2: random resync pulses
  task automatic run(input int ncyc, input int mode, input bit bwrite);
    for (int i = 0; i < ncyc; i++) begin
      bit a = (mode == 1 && mpos == 1023) || (mode == 2 && $urandom % 700 == 0);
      bit fw = bwrite && mpos == 1023;
      cyc(a, fw);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int b = 0; b < 2; b++)
      for (int l = 0; l < 4; l++)
        for (int t = 0; t < 32; t++) mb[b][l][t] = '0;
    mpos = 1023;
    mrb = 0;
    tag = "R1";
    repeat (3) @(negedge clk);
    chk(sd_a, 1'b0, "R1 reset sd_a");
    chk(sg_a, 1'b0, "R1 reset sg_a");
    chk(sd_b, 1'b0, "R1 reset sd_b");
    chk(sg_b, 1'b0, "R1 reset sg_b");
    rst_n = 1'b1;
    tag = "R1/R2/R5/R8"; run(3 * 1024, 0, 0);
    tag = "R7 aligned";  run(2 * 1024, 1, 0);
    tag = "R7 resync";   run(2 * 1024, 2, 0);
    fp_inv = 1'b1; fp_in = 1'b1;
    tag = "R6 inverted"; run(1024, 1, 0);
    tag = "R6/R7 inv";   run(1024, 2, 0);
    fp_inv = 1'b0; fp_in = 1'b0;
    tag = "R10 boundary write"; run(3 * 1024, 0, 1);
    tag = "R10 pulse write";    run(2 * 1024, 1, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule